// File: doc/BRIEF.md
# Paper Tape Punch Cycle Sequencer

This block runs one character punch cycle of a paper tape punch from a single request pulse. The request input first passes two synchronising flops and a glitch filter, so a pulse has to stay high for a set number of clock cycles before it counts. A qualified rising request is accepted only while no cycle is running. On acceptance the 9-bit character is taken into a holding register. A feed phase follows, then a record phase. During the record phase the held character drives the solenoid outputs and a strobe is raised for external use.

The stepper enable stays high over the whole feed plus record span, so the tape stands still while the holes are made. The motor receives one step pulse per cycle. A separate cycle timer starts at acceptance and outlasts both phases. It drives the ready output, which falls a short delay after capture and rises only when the timer expires. This caps throughput at about 75 characters per second with the default timing.

All durations are parameters in clock cycles. By default they are derived from `CLK_HZ` (1 MHz): 10 us filter, 70 us ready delay, 10.5 ms feed, 1.85 ms record and 13.333 ms total cycle.

Top module: `punch_seq`

## Requirements
- R1: The request must be sampled high for at least `FILT_CYC` consecutive cycles after the two-flop synchroniser, or no cycle starts. When this holds, the cycle starts at rising edge number `FILT_CYC`+2, counted from the first edge that samples the request high. A start shows as `motorEnable` and `stepClk` high after that edge.
- R2: A cycle starts only when no cycle is running, which requires `punchReady` high and the cycle timer expired. A qualified request that arrives during a cycle is dropped. A request held high across the end of a cycle does not start a new one: a fresh rise is needed.
- R3: The character on `charIn` is captured at the start edge, and later changes on `charIn` do not affect it. `punchReady` goes low `BUSY_CYC` edges after the start edge.
- R4: The feed phase lasts `FEED_CYC` cycles from the start edge. The record phase follows at once and lasts `REC_CYC` cycles.
- R5: `solenoidOut` equals the captured character only during the record phase and is all zeros at every other time. `recStrobe` is high exactly during the record phase.
- R6: The holding register clears at the edge that ends the record phase. `solenoidOut` is zero from then on, and the next cycle shows only its own newly captured character.
- R7: `punchReady` returns high exactly `CYCLE_CYC` edges after the start edge. It stays low after the record phase ends until then.
- R8: `motorEnable` is high for the whole feed plus record span and low otherwise. `stepClk` is a single one-cycle pulse in the first cycle of each punch cycle.
- R9: A synchronous active-high `rst` aborts any cycle. After the reset edge `punchReady` is high, and `solenoidOut`, `recStrobe`, `motorEnable` and `stepClk` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timing clock |
| rst | input | 1 | Synchronous active-high reset |
| punchReq | input | 1 | Asynchronous punch request pulse |
| charIn | input | 9 | Character to punch, taken at cycle start |
| punchReady | output | 1 | High when ready, low while busy |
| solenoidOut | output | 9 | Punch solenoid drive, live in record phase only |
| recStrobe | output | 1 | Record-phase strobe for external use |
| motorEnable | output | 1 | Stepper drive enable over feed plus record |
| stepClk | output | 1 | One-cycle step pulse per punch cycle |

## Verification
The bench builds the block with short overrides: a 4-cycle filter, a 7-cycle ready delay, 40 feed cycles, 12 record cycles and a 70-cycle total period. With these values every phase edge can be checked cycle by cycle within a few hundred clocks. They also bring within reach pulses one cycle too short for the filter, requests that land or stay high inside a busy window, back-to-back cycles that start on the first ready cycle, and a reset in the middle of the record phase.

// File: rtl/punch_pkg.sv
package punch_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FEED = 2'd1,
    PH_REC  = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
    logic drive;
  } dp_strobe_t;

endpackage

// File: rtl/punch_qual.sv
module punch_qual #(
  parameter int FILT_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic reqIn,
  output logic qualRise
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
  localparam logic [CW-1:0] SAT  = CW'(FILT_CYC);

  logic syncA, syncB;
  logic [CW-1:0] highCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      highCnt <= '0;
    end else begin
      syncA <= reqIn;
      syncB <= syncA;
      if (!syncB)
        highCnt <= '0;
      else if (highCnt != SAT)
        highCnt <= highCnt + 1'b1;
    end
  end

  // one pulse when the synced level has been high FILT_CYC cycles
  assign qualRise = syncB && (highCnt == LAST);

  // R1: a qualified rise needs the synced level high now and before
  p_filter_hold_r1: assert property (@(posedge clk) disable iff (rst)
    qualRise && (FILT_CYC > 1) |-> syncB && $past(syncB));

  // R1: the filter fires once per high level
  p_single_rise_r1: assert property (@(posedge clk) disable iff (rst)
    qualRise |=> !qualRise);

endmodule

// File: rtl/punch_dp.sv
module punch_dp
  import punch_pkg::*;
#(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_strobe_t        strb,
  input  logic [CHAR_W-1:0] charIn,
  output logic [CHAR_W-1:0] solenoidOut
);
  logic [CHAR_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (rst || strb.clear)
      holdReg <= '0;
    else if (strb.capture)
      holdReg <= charIn;
  end

  assign solenoidOut = strb.drive ? holdReg : '0;

  // R6: register is empty once the record phase has ended
  p_clear_after_rec_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(strb.drive) |-> holdReg == '0);

  // R5: the punched pattern does not change inside the record phase
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    strb.drive && $past(strb.drive) |-> $stable(solenoidOut));

endmodule

// File: rtl/punch_ctrl.sv
module punch_ctrl
  import punch_pkg::*;
#(
  parameter int BUSY_CYC  = 70,
  parameter int FEED_CYC  = 10500,
  parameter int REC_CYC   = 1850,
  parameter int CYCLE_CYC = 13333
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       qualRise,
  output dp_strobe_t strb,
  output logic       ready,
  output logic       motorEn,
  output logic       recPhase,
  output logic       stepPulse
);
  localparam int PH_MAX = (FEED_CYC > REC_CYC) ? FEED_CYC : REC_CYC;
  localparam int PW = $clog2(PH_MAX + 1);
  localparam int TW = $clog2(CYCLE_CYC + 1);
  localparam logic [PW-1:0] FEED_LAST = PW'(FEED_CYC - 1);
  localparam logic [PW-1:0] REC_LAST  = PW'(REC_CYC - 1);
  localparam logic [TW-1:0] CYC_LAST  = TW'(CYCLE_CYC - 1);
  localparam logic [TW-1:0] BUSY_AT   = TW'(BUSY_CYC);

  initial begin
    a_param_order: assert (BUSY_CYC < FEED_CYC && FEED_CYC + REC_CYC < CYCLE_CYC)
      else $error("punch_ctrl: timing parameters out of order");
  end

  phase_t        phase;
  logic [PW-1:0] phCnt;
  logic [TW-1:0] cycCnt;
  logic          active;
  logic          start;

  assign start = qualRise && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      phCnt     <= '0;
      cycCnt    <= '0;
      active    <= 1'b0;
      stepPulse <= 1'b0;
    end else begin
      stepPulse <= start;

      // throughput timer, independent of the phases
      if (start) begin
        active <= 1'b1;
        cycCnt <= '0;
      end else if (active) begin
        if (cycCnt == CYC_LAST) begin
          active <= 1'b0;
          cycCnt <= '0;
        end else begin
          cycCnt <= cycCnt + 1'b1;
        end
      end

      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_FEED;
          phCnt <= '0;
        end
        PH_FEED: if (phCnt == FEED_LAST) begin
          phase <= PH_REC;
          phCnt <= '0;
        end else begin
          phCnt <= phCnt + 1'b1;
        end
        PH_REC: if (phCnt == REC_LAST) begin
          phase <= PH_IDLE;
          phCnt <= '0;
        end else begin
          phCnt <= phCnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign ready        = !(active && cycCnt >= BUSY_AT);
  assign motorEn      = (phase != PH_IDLE);
  assign recPhase     = (phase == PH_REC);
  assign strb.capture = start;
  assign strb.drive   = recPhase;
  assign strb.clear   = recPhase && (phCnt == REC_LAST);

  // R2: a capture only happens from idle with ready high
  p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
    strb.capture |-> ready && phase == PH_IDLE);

  // R3: ready falls while the feed phase is running
  p_busy_in_feed_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> phase == PH_FEED);

  // R4: the record phase is entered only from the feed phase
  p_rec_after_feed_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(recPhase) |-> $past(phase) == PH_FEED);

  // R7: ready rises only after both phases are over
  p_ready_late_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> phase == PH_IDLE && !motorEn);

  // R8: the step pulse lasts one cycle
  p_step_once_r8: assert property (@(posedge clk) disable iff (rst)
    stepPulse |=> !stepPulse && motorEn);

endmodule

// File: rtl/punch_seq.sv
module punch_seq
  import punch_pkg::*;
#(
  parameter int CLK_HZ    = 1_000_000,
  parameter int CHAR_W    = 9,
  parameter int FILT_CYC  = CLK_HZ / 100_000,
  parameter int BUSY_CYC  = CLK_HZ / 100_000 * 7,
  parameter int FEED_CYC  = CLK_HZ / 1000 * 21 / 2,
  parameter int REC_CYC   = CLK_HZ / 1000 * 37 / 20,
  parameter int CYCLE_CYC = CLK_HZ / 1000 * 40 / 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              punchReq,
  input  logic [CHAR_W-1:0] charIn,
  output logic              punchReady,
  output logic [CHAR_W-1:0] solenoidOut,
  output logic              recStrobe,
  output logic              motorEnable,
  output logic              stepClk
);
  logic       qualRise;
  dp_strobe_t strb;

  punch_qual #(.FILT_CYC(FILT_CYC)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .reqIn    (punchReq),
    .qualRise (qualRise)
  );

  punch_ctrl #(
    .BUSY_CYC  (BUSY_CYC),
    .FEED_CYC  (FEED_CYC),
    .REC_CYC   (REC_CYC),
    .CYCLE_CYC (CYCLE_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .qualRise  (qualRise),
    .strb      (strb),
    .ready     (punchReady),
    .motorEn   (motorEnable),
    .recPhase  (recStrobe),
    .stepPulse (stepClk)
  );

  punch_dp #(.CHAR_W(CHAR_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .charIn      (charIn),
    .solenoidOut (solenoidOut)
  );

  // R5: no solenoid is driven outside the record strobe
  p_sol_only_rec_r5: assert property (@(posedge clk) disable iff (rst)
    !recStrobe |-> solenoidOut == '0);

endmodule

// File: tb/tb_punch_seq.sv
module tb_punch_seq;
  localparam int F   = 4;
  localparam int D   = 7;
  localparam int FD  = 40;
  localparam int RC  = 12;
  localparam int CYC = 70;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, punchReq;
  logic [8:0] charIn;
  logic       punchReady, recStrobe, motorEnable, stepClk;
  logic [8:0] solenoidOut;

  punch_seq #(
    .FILT_CYC(F), .BUSY_CYC(D), .FEED_CYC(FD), .REC_CYC(RC), .CYCLE_CYC(CYC)
  ) dut (
    .clk(clk), .rst(rst), .punchReq(punchReq), .charIn(charIn),
    .punchReady(punchReady), .solenoidOut(solenoidOut), .recStrobe(recStrobe),
    .motorEnable(motorEnable), .stepClk(stepClk)
  );

  int checks = 0;
  int fails  = 0;
  int k      = 0;

  task automatic chkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic negs(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic goK(int target);
    negs(target - k);
    k = target;
  endtask

  // issue a request and stop at k=0, the negedge after the start edge
  task automatic startCycle(logic [8:0] data);
    charIn   = data;
    punchReq = 1'b1;
    negs(F);
    punchReq = 1'b0;
    negs(1);
    chkEq("R1 no start before filter edge", int'(motorEnable), 0);
    negs(1);
    k = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1; punchReq = 1'b0; charIn = '0;
    negs(3);
    rst = 1'b0;
    negs(1);
    chkEq("R9 reset ready", int'(punchReady), 1);
    chkEq("R9 reset solenoids", int'(solenoidOut), 0);
    chkEq("R9 reset strobe", int'(recStrobe), 0);
    chkEq("R9 reset motor", int'(motorEnable), 0);
    chkEq("R9 reset step", int'(stepClk), 0);
  endtask

  task automatic t_short();
    int seen = 0;
    punchReq = 1'b1;
    negs(F - 1);
    punchReq = 1'b0;
    for (int i = 0; i < 30; i++) begin
      negs(1);
      if (motorEnable || stepClk || !punchReady) seen++;
    end
    chkEq("R1 short pulse ignored", seen, 0);
  endtask

  task automatic t_full(logic [8:0] data);
    startCycle(data);
    chkEq("R1 start motor", int'(motorEnable), 1);
    chkEq("R8 step pulse", int'(stepClk), 1);
    chkEq("R3 ready before delay", int'(punchReady), 1);
    goK(1);
    chkEq("R8 step one cycle", int'(stepClk), 0);
    goK(D - 1);
    chkEq("R3 ready still high", int'(punchReady), 1);
    goK(D);
    chkEq("R3 ready low", int'(punchReady), 0);
    goK(FD - 1);
    chkEq("R4 feed strobe low", int'(recStrobe), 0);
    chkEq("R5 feed solenoids zero", int'(solenoidOut), 0);
    chkEq("R8 motor in feed", int'(motorEnable), 1);
    goK(FD);
    chkEq("R4 record begins", int'(recStrobe), 1);
    chkEq("R5 record solenoids", int'(solenoidOut), int'(data));
    chkEq("R8 motor in record", int'(motorEnable), 1);
    goK(FD + RC - 1);
    chkEq("R4 record last", int'(recStrobe), 1);
    chkEq("R5 record solenoids last", int'(solenoidOut), int'(data));
    goK(FD + RC);
    chkEq("R4 record ends", int'(recStrobe), 0);
    chkEq("R6 solenoids cleared", int'(solenoidOut), 0);
    chkEq("R8 motor off", int'(motorEnable), 0);
    chkEq("R7 ready held after record", int'(punchReady), 0);
    goK(CYC - 1);
    chkEq("R7 ready low at last cycle", int'(punchReady), 0);
    goK(CYC);
    chkEq("R7 ready returns", int'(punchReady), 1);
  endtask

  task automatic t_busy();
    int seen = 0;
    startCycle(9'h0C3);
    charIn = 9'h13C;
    goK(10);
    punchReq = 1'b1;
    negs(F + 2);
    k += F + 2;
    punchReq = 1'b0;
    goK(FD);
    chkEq("R3 capture unaffected by later data", int'(solenoidOut), 'h0C3);
    goK(CYC);
    chkEq("R7 ready after busy request", int'(punchReady), 1);
    for (int i = 0; i < 20; i++) begin
      negs(1);
      if (motorEnable) seen++;
    end
    chkEq("R2 request during busy dropped", seen, 0);
  endtask

  task automatic t_held();
    startCycle(9'h055);
    goK(20);
    punchReq = 1'b1;
    goK(CYC + 10);
    chkEq("R2 held request no restart", int'(motorEnable), 0);
    chkEq("R2 held request ready", int'(punchReady), 1);
    punchReq = 1'b0;
    negs(3);
    t_full(9'h1FF);
  endtask

  task automatic t_backToBack();
    t_full(9'h1AA);
    t_full(9'h001);
    chkEq("R6 next cycle idle after", int'(solenoidOut), 0);
  endtask

  task automatic t_resetMid();
    startCycle(9'h0F0);
    goK(FD + 3);
    chkEq("R5 solenoids before reset", int'(solenoidOut), 'h0F0);
    rst = 1'b1;
    negs(1);
    rst = 1'b0;
    chkEq("R9 abort ready", int'(punchReady), 1);
    chkEq("R9 abort solenoids", int'(solenoidOut), 0);
    chkEq("R9 abort strobe", int'(recStrobe), 0);
    chkEq("R9 abort motor", int'(motorEnable), 0);
    negs(5);
    chkEq("R9 stays idle", int'(motorEnable), 0);
    t_full(9'h10F);
  endtask

  initial begin
    negs(1);
    t_reset();
    t_short();
    t_full(9'h1A5);
    t_busy();
    t_held();
    t_backToBack();
    t_resetMid();
    negs(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule